// File: doc/BRIEF.md
# Framed SPI Frame-Sync Unit

This unit adds framed transfers to a serial shifter. In framed operation the select line no longer acts as a chip select. It carries a short frame synchronization pulse that marks where each data word begins. When the unit is frame master, it drives that pulse each time a word is loaded for sending. When it is frame slave, it watches the sync pin at each serial clock and begins a word once it sees the pulse at its active level.

The serial clock arrives as an input, whether a local generator or a remote master produces it. The unit finds the leading edges (leaving the idle level) and the trailing edges (returning to idle) against the system clock. Data leaves on leading edges, most significant bit first, and the receive side samples on trailing edges. The clock-edge selection of ordinary SPI therefore plays no part here. Several settings are chosen independently: the sync polarity, whether the sync pulse shares the first data bit's clock period or takes the period just before it, and frame master or slave. A holding register keeps the last written word. A frame triggered by the sync pin sends that word again when nothing new was written.

Top module: `fsync_unit`

## Requirements
- R1: Sync polarity: with `cfg_sync_high`=1 the active sync level is 1, otherwise it is 0. A driven pulse uses the active level, and a frame slave starts only on the active level.
- R2: With `cfg_sync_early`=0 the first data bit (`word_start_o`, first `tx_edge_o`) falls in the same serial clock period as the sync pulse. With `cfg_sync_early`=1 it falls in the next period.
- R3: As frame master (`cfg_frm_master`=1), a write to the holding register makes the unit drive the sync pulse from the next leading edge. The pulse lasts exactly one serial clock period, from one leading edge to the next.
- R4: As frame slave, an active sync level sampled at a leading edge starts a frame with no write needed. The word sent is the current holding register, which is the last written value.
- R5: A frame gives exactly `WORD_W` transmit strobes on successive leading edges. `tx_bit_o` presents the word most significant bit first, and `word_o` shows that word while `word_start_o` is high.
- R6: An active sync level seen while a frame is in progress has no effect: no second `word_start_o` occurs in that frame.
- R7: Receive strobes (`rx_edge_o`) occur only on trailing edges within a frame, exactly `WORD_W` per frame. The first one falls in the first data bit's period. `busy_o` drops together with the last one.
- R8: A frame master with no pending write starts no frame.
- R9: After reset: `busy_o`=0, `word_start_o`=0, `tx_edge_o`=0, `rx_edge_o`=0, and `sync_o` at the inactive level.
- R10: `cfg_clk_idle_high` sets the idle level of the serial clock. The leading and trailing edges are taken relative to it.
- R11: `sync_oe_o` is 1 only for frame master. A frame slave never drives the sync line active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_frm_master | input | 1 | 1: drive sync pulse, 0: receive it |
| cfg_sync_high | input | 1 | Active level of the sync pulse |
| cfg_sync_early | input | 1 | 1: sync one period before first bit |
| cfg_clk_idle_high | input | 1 | Idle level of serial clock |
| sclk_i | input | 1 | Serial clock level |
| sync_i | input | 1 | Sync pin level (frame slave) |
| hold_wr_i | input | 1 | Write strobe for holding register |
| hold_data_i | input | WORD_W | Word to hold |
| sync_o | output | 1 | Sync line drive value |
| sync_oe_o | output | 1 | Sync line drive enable |
| word_start_o | output | 1 | Strobe to shifter: first data bit begins |
| word_o | output | WORD_W | Word being sent |
| tx_bit_o | output | 1 | Current outgoing data bit |
| tx_edge_o | output | 1 | Strobe: new bit presented |
| rx_edge_o | output | 1 | Strobe: sample incoming bit |
| busy_o | output | 1 | Frame in progress |

## Verification
A corrupted bit counter shows up within one frame. `busy_o` would fall after too many or too few receive strobes, and the word would be cut short or run past `WORD_W` transmit strobes. A stuck or misrouted state in the start logic shows up at the first leading edge after a write or a sync pulse. Such a fault moves `word_start_o` by one serial clock period, widens or omits the sync pulse, or restarts a frame on a sync seen mid-word. All of these can be seen from the start strobe, the sync line and the collected transmit bits within `WORD_W`+1 serial clock periods.

// File: rtl/fsync_pkg.sv
package fsync_pkg;
    typedef enum logic [1:0] {
        FS_IDLE  = 2'd0,
        FS_LEAD  = 2'd1,
        FS_SHIFT = 2'd2
    } fs_state_e;
endpackage

// File: rtl/fsync_sclk_edge.sv
module fsync_sclk_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_i,
    input  logic idle_hi_i,
    output logic lead_o,
    output logic trail_o
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d  = sclk_i;
        // leading: was at idle level, now away from it
        lead_o  = (sclk_i ^ idle_hi_i) & ~(prev_q ^ idle_hi_i);
        // trailing: was away from idle, now back at it
        trail_o = ~(sclk_i ^ idle_hi_i) & (prev_q ^ idle_hi_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/fsync_hold.sv
module fsync_hold #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [WORD_W-1:0] data_i,
    input  logic              take_i,
    output logic [WORD_W-1:0] hold_o,
    output logic              pend_o
);
    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic              pend;
    } hold_t;

    hold_t h_d, h_q;

    always_comb begin
        h_d = h_q;
        if (wr_i) begin
            h_d.word = data_i;
            h_d.pend = 1'b1;
        end else if (take_i) begin
            h_d.pend = 1'b0;
        end
        hold_o = h_q.word;
        pend_o = h_q.pend;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) h_q <= '0;
        else        h_q <= h_d;
    end
endmodule

// File: rtl/fsync_txser.sv
module fsync_txser #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic              adv_i,
    output logic              tx_bit_o,
    output logic              tx_edge_o
);
    typedef struct packed {
        logic [WORD_W-1:0] sh;
        logic              bit_out;
        logic              edge_out;
    } ser_t;

    ser_t s_d, s_q;

    always_comb begin
        s_d          = s_q;
        s_d.edge_out = 1'b0;
        if (load_i) begin
            s_d.bit_out  = word_i[WORD_W-1];
            s_d.sh       = {word_i[WORD_W-2:0], 1'b0};
            s_d.edge_out = 1'b1;
        end else if (adv_i) begin
            s_d.bit_out  = s_q.sh[WORD_W-1];
            s_d.sh       = {s_q.sh[WORD_W-2:0], 1'b0};
            s_d.edge_out = 1'b1;
        end
        tx_bit_o  = s_q.bit_out;
        tx_edge_o = s_q.edge_out;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/fsync_unit.sv
module fsync_unit
    import fsync_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_frm_master,
    input  logic              cfg_sync_high,
    input  logic              cfg_sync_early,
    input  logic              cfg_clk_idle_high,
    input  logic              sclk_i,
    input  logic              sync_i,
    input  logic              hold_wr_i,
    input  logic [WORD_W-1:0] hold_data_i,
    output logic              sync_o,
    output logic              sync_oe_o,
    output logic              word_start_o,
    output logic [WORD_W-1:0] word_o,
    output logic              tx_bit_o,
    output logic              tx_edge_o,
    output logic              rx_edge_o,
    output logic              busy_o
);
    localparam int CNT_W = (WORD_W > 2) ? $clog2(WORD_W) : 1;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);

    typedef struct packed {
        fs_state_e         st;
        logic [CNT_W-1:0]  cnt;
        logic              sync_on;
        logic              start;
        logic              rx_edge;
        logic [WORD_W-1:0] word;
    } ctl_t;

    ctl_t c_d, c_q;

    logic              lead, trail;
    logic              pend;
    logic [WORD_W-1:0] hold;
    logic              take;
    logic              begin_data;
    logic              shift_adv;
    logic [WORD_W-1:0] load_word;
    logic              sync_seen;

    fsync_sclk_edge u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_i    (sclk_i),
        .idle_hi_i (cfg_clk_idle_high),
        .lead_o    (lead),
        .trail_o   (trail)
    );

    fsync_hold #(.WORD_W(WORD_W)) u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_i   (hold_wr_i),
        .data_i (hold_data_i),
        .take_i (take),
        .hold_o (hold),
        .pend_o (pend)
    );

    fsync_txser #(.WORD_W(WORD_W)) u_ser (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (begin_data),
        .word_i    (load_word),
        .adv_i     (shift_adv),
        .tx_bit_o  (tx_bit_o),
        .tx_edge_o (tx_edge_o)
    );

    always_comb begin
        c_d         = c_q;
        c_d.start   = 1'b0;
        c_d.rx_edge = 1'b0;
        take        = 1'b0;
        begin_data  = 1'b0;
        shift_adv   = 1'b0;
        load_word   = c_q.word;
        sync_seen   = (sync_i == cfg_sync_high);

        unique case (c_q.st)
            FS_IDLE: begin
                if (lead && (cfg_frm_master ? pend : sync_seen)) begin
                    take        = 1'b1;
                    c_d.word    = hold;
                    c_d.sync_on = cfg_frm_master;
                    if (cfg_sync_early) begin
                        c_d.st = FS_LEAD;
                    end else begin
                        c_d.st     = FS_SHIFT;
                        begin_data = 1'b1;
                        load_word  = hold;
                    end
                end
            end
            FS_LEAD: begin
                if (lead) begin
                    c_d.st      = FS_SHIFT;
                    c_d.sync_on = 1'b0;
                    begin_data  = 1'b1;
                end
            end
            FS_SHIFT: begin
                if (lead) begin
                    c_d.sync_on = 1'b0;
                    shift_adv   = 1'b1;
                end
                if (trail) begin
                    c_d.rx_edge = 1'b1;
                    if (c_q.cnt == LAST_BIT) begin
                        c_d.st  = FS_IDLE;
                        c_d.cnt = '0;
                    end else begin
                        c_d.cnt = c_q.cnt + 1'b1;
                    end
                end
            end
            default: c_d.st = FS_IDLE;
        endcase

        if (begin_data) begin
            c_d.start = 1'b1;
            c_d.cnt   = '0;
        end

        sync_o       = c_q.sync_on ? cfg_sync_high : ~cfg_sync_high;
        sync_oe_o    = cfg_frm_master;
        word_start_o = c_q.start;
        word_o       = c_q.word;
        rx_edge_o    = c_q.rx_edge;
        busy_o       = (c_q.st != FS_IDLE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q    <= '0;
            c_q.st <= FS_IDLE;
        end else begin
            c_q <= c_d;
        end
    end
endmodule

// File: rtl/fsync_unit_chk.sv
module fsync_unit_chk #(
    parameter int WORD_W = 16
) (
    input logic clk,
    input logic rst_n,
    input logic cfg_sync_high,
    input logic sync_o,
    input logic sync_oe_o,
    input logic word_start_o,
    input logic tx_edge_o,
    input logic rx_edge_o,
    input logic busy_o
);
    localparam int TC_W = $clog2(WORD_W + 2) + 1;
    logic [TC_W-1:0] tx_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             tx_cnt <= '0;
        else if (word_start_o)  tx_cnt <= TC_W'(tx_edge_o);
        else if (tx_edge_o)     tx_cnt <= tx_cnt + 1'b1;
    end

    // R5
    word_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> (tx_cnt == TC_W'(WORD_W)));

    // R3
    sync_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_oe_o && (sync_o == cfg_sync_high)) |-> busy_o);

    // R7
    edge_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_edge_o && rx_edge_o));

    // R2
    start_first_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_start_o |-> (busy_o && tx_edge_o));

    // R6
    start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_start_o |=> !word_start_o);

    // R7
    end_on_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> rx_edge_o);
endmodule

bind fsync_unit fsync_unit_chk #(.WORD_W(WORD_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_sync_high(cfg_sync_high),
    .sync_o       (sync_o),
    .sync_oe_o    (sync_oe_o),
    .word_start_o (word_start_o),
    .tx_edge_o    (tx_edge_o),
    .rx_edge_o    (rx_edge_o),
    .busy_o       (busy_o)
);

// File: tb/fsync_unit_bench.sv
`timescale 1ns/1ps
module fsync_unit_bench;
    localparam int W    = 16;
    localparam int HALF = 3;
    localparam int NV   = 6;
    // fields: [20] frame master, [19] polarity, [18] early, [17] clk idle high, [16] write, [15:0] data
    localparam logic [20:0] VEC [NV] = '{
        {1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 16'hA5C3},
        {1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 16'h8001},
        {1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 16'h1234},
        {1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 16'hFFFE},
        {1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 16'h0000},
        {1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 16'h0F0F}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_frm_master = 1'b1;
    logic cfg_sync_high = 1'b1;
    logic cfg_sync_early = 1'b0;
    logic cfg_clk_idle_high = 1'b0;
    logic sclk = 1'b0;
    logic sync_in = 1'b0;
    logic hold_wr = 1'b0;
    logic [W-1:0] hold_data = '0;
    logic sync_o, sync_oe_o, word_start_o, tx_bit_o, tx_edge_o, rx_edge_o, busy_o;
    logic [W-1:0] word_o;

    int checks = 0;
    int fails = 0;
    int cur_period = -1;
    logic cur_pol = 1'b1;
    int mon_starts, mon_start_p, mon_nbits, mon_nrx, mon_rx_p, mon_sync_cyc, mon_sync_p;
    logic [W-1:0] mon_word, mon_bits;
    logic [W-1:0] last_wr = '0;

    always #2 clk = ~clk;

    fsync_unit #(.WORD_W(W)) u_fsync_unit (
        .clk(clk), .rst_n(rst_n),
        .cfg_frm_master(cfg_frm_master), .cfg_sync_high(cfg_sync_high),
        .cfg_sync_early(cfg_sync_early), .cfg_clk_idle_high(cfg_clk_idle_high),
        .sclk_i(sclk), .sync_i(sync_in), .hold_wr_i(hold_wr), .hold_data_i(hold_data),
        .sync_o(sync_o), .sync_oe_o(sync_oe_o), .word_start_o(word_start_o),
        .word_o(word_o), .tx_bit_o(tx_bit_o), .tx_edge_o(tx_edge_o),
        .rx_edge_o(rx_edge_o), .busy_o(busy_o)
    );

    always @(negedge clk) begin
        if (word_start_o) begin
            mon_starts  = mon_starts + 1;
            mon_start_p = cur_period;
            mon_word    = word_o;
        end
        if (tx_edge_o) begin
            mon_bits  = {mon_bits[W-2:0], tx_bit_o};
            mon_nbits = mon_nbits + 1;
        end
        if (rx_edge_o) begin
            if (mon_nrx == 0) mon_rx_p = cur_period;
            mon_nrx = mon_nrx + 1;
        end
        if (sync_o == cur_pol) begin
            if (mon_sync_cyc == 0) mon_sync_p = cur_period;
            mon_sync_cyc = mon_sync_cyc + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic run_frame(input logic m, input logic p, input logic e, input logic k,
                             input logic w, input logic [W-1:0] d,
                             input logic s0, input logic s3);
        @(negedge clk);
        cfg_frm_master = m; cfg_sync_high = p; cfg_sync_early = e;
        cfg_clk_idle_high = k; sclk = k; sync_in = ~p; cur_pol = p;
        repeat (4) @(negedge clk);
        cur_period = -1;
        mon_starts = 0; mon_start_p = -1; mon_nbits = 0; mon_nrx = 0;
        mon_rx_p = -1; mon_sync_cyc = 0; mon_sync_p = -1;
        mon_word = '0; mon_bits = '0;
        if (w) begin
            hold_wr = 1'b1; hold_data = d;
            @(negedge clk);
            hold_wr = 1'b0;
            last_wr = d;
        end
        repeat (2) @(negedge clk);
        for (int i = 0; i < W + 4; i++) begin
            cur_period = i;
            sclk = ~k;
            sync_in = ((i == 0 && s0) || (i == 3 && s3)) ? p : ~p;
            repeat (HALF) @(negedge clk);
            sclk = k;
            repeat (HALF) @(negedge clk);
        end
        sync_in = ~p;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9 reset state
        chk(busy_o == 1'b0, "R9", "busy in reset", busy_o, 0);
        chk(word_start_o == 1'b0 && tx_edge_o == 1'b0 && rx_edge_o == 1'b0,
            "R9", "strobes in reset", {word_start_o, tx_edge_o, rx_edge_o}, 0);
        chk(sync_o == 1'b0, "R9", "sync inactive in reset", sync_o, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(busy_o == 1'b0 && sync_o == 1'b0, "R9", "idle after reset", {busy_o, sync_o}, 0);

        for (int v = 0; v < NV; v++) begin
            logic m, p, e, k, w;
            logic [W-1:0] d, exp_word;
            int exp_start;
            {m, p, e, k, w, d} = VEC[v];
            exp_word  = w ? d : last_wr;
            exp_start = e ? 1 : 0;
            run_frame(m, p, e, k, w, d, !m, 1'b0);
            chk(mon_starts == 1, "R3/R4", "frame count", mon_starts, 1);
            chk(mon_start_p == exp_start, "R2/R10", "start period", mon_start_p, exp_start);
            chk(mon_word == exp_word, "R4/R5", "word at start", mon_word, exp_word);
            chk(mon_nbits == W && mon_bits == exp_word, "R5", "serial bits msb first",
                mon_bits, exp_word);
            chk(mon_nrx == W, "R7", "rx strobe count", mon_nrx, W);
            chk(mon_rx_p == exp_start, "R7", "first rx period", mon_rx_p, exp_start);
            chk(sync_oe_o == m, "R11", "sync drive enable", sync_oe_o, m);
            if (m) begin
                chk(mon_sync_cyc == 2 * HALF, "R3/R1", "sync width in clk", mon_sync_cyc, 2 * HALF);
                chk(mon_sync_p == 0, "R2", "sync period", mon_sync_p, 0);
            end else begin
                chk(mon_sync_cyc == 0, "R11", "slave never drives active", mon_sync_cyc, 0);
            end
        end

        // R6: extra sync during the word is ignored
        run_frame(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 16'h5A5A, 1'b1, 1'b1);
        chk(mon_starts == 1, "R6", "sync mid-word ignored", mon_starts, 1);
        chk(mon_nbits == W && mon_bits == 16'h5A5A, "R6", "word intact", mon_bits, 16'h5A5A);

        // R8: master with nothing written starts nothing
        run_frame(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0);
        chk(mon_starts == 0, "R8", "no frame without write", mon_starts, 0);
        chk(mon_sync_cyc == 0, "R8", "no sync without write", mon_sync_cyc, 0);

        // R1: slave with sync held at the inactive level starts nothing
        run_frame(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0);
        chk(mon_starts == 0, "R1", "inactive sync level ignored", mon_starts, 0);
        chk(busy_o == 1'b0, "R1", "idle after inactive sync", busy_o, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule